// File: doc/BRIEF.md
# Triple-Port Parallel I/O Interface

This block is a memory-mapped parallel I/O peripheral for an 8-bit processor bus. It has three 8-bit ports, called A, B and C. Each port has its own output latch and its own direction register, and a 1 in a direction bit makes that pin an output. The block occupies eight byte slots: the three port data registers, the three direction registers and two control slots. The pad drivers sit outside the block. For each port, the block presents a value vector and an enable vector to those drivers, and it takes the pin levels back as input vectors.

The eight-byte window sits at one of two fixed bases. An external device-select input picks the base, and nothing else moves the block. A write takes effect on the clock edge when the write strobe is high and the address falls inside the active window. Read data is formed combinationally. It is driven only while the read strobe is high and the window is hit, and it is zero at all other times. Only some bits of ports B and C are in use. Bits that are not in use are not stored, and they always read as zero. This keeps the register count down.

Top module: `tri_port_pio`

## Requirements
- R1: After reset, all three port latches, all three direction registers and both control slots hold 0x00, so every enable output and every value output is 0 and every pin is an input.
- R2: The offset within the window is the address modulo 8. Offset 0 is port A data, 1 is port B data, 2 is port C data, 3 is port A direction, 4 is port B direction and 5 is port C direction. A write lands in the addressed register on the clock edge where `wr_en` is high.
- R3: With `dev_sel` = 1 the window covers 0xFEF0 to 0xFEF7. With `dev_sel` = 0 it covers 0xFEC0 to 0xFEC7. An access outside the active window writes nothing and reads 0.
- R4: A read of a port data register returns, bit by bit, the latch value where the direction bit is 1 and the pin level where it is 0. A read of a direction register returns the stored value.
- R5: For each port, the enable output equals that port's direction register and the value output equals that port's latch.
- R6: Port A uses all 8 bits. Port B uses bits 0–1 and port C uses bits 6–7. Every other bit of ports B and C ignores writes and always reads 0, whatever its pin level. Its enable output and value output are also 0.
- R7: Offsets 6 and 7 are two 8-bit control registers that can be read and written. Both reset to 0x00.
- R8: `rdata` is 0x00 whenever `rd_en` is low, even if the address is inside the window.
- R9: The standard start-up sequence writes 0xFF to A direction, 0x00 to B direction, 0x40 to C direction, 0x00 to A data and 0x40 to C data. After it, port A drives 0x00 on all pins, port C bit 6 is a high output and port C bit 7 is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| dev_sel | input | 1 | Window select: 1 selects base 0xFEF0, 0 selects base 0xFEC0 |
| rdata | output | 8 | Read data, 0 when no read hits the window |
| pin_a | input | 8 | Port A pin levels |
| pin_b | input | 8 | Port B pin levels |
| pin_c | input | 8 | Port C pin levels |
| out_a | output | 8 | Port A output values |
| out_b | output | 8 | Port B output values |
| out_c | output | 8 | Port C output values |
| oe_a | output | 8 | Port A output enables |
| oe_b | output | 8 | Port B output enables |
| oe_c | output | 8 | Port C output enables |

## Verification
Every writable slot is swept through all 256 data values and read back. Comparing each read-back against the bit mask of its port separates stored bits from unused bits. For the data reads, a walking set of direction patterns is applied against pin patterns that are the complement of the latch. This way each bit of the read-back shows whether the latch path or the pin path was taken. The same registers are written through both window bases under both `dev_sel` levels, and at addresses just outside each window. Only the matching window may take the write, which separates decoding on the select line from decoding on the address alone. Finally, the start-up sequence is replayed and the pad outputs are checked.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int unsigned SLOT_W   = 3;
   localparam int unsigned N_PORTS  = 3;

   typedef enum logic [SLOT_W-1:0] {
      SL_DAT_A = 3'd0,
      SL_DAT_B = 3'd1,
      SL_DAT_C = 3'd2,
      SL_DIR_A = 3'd3,
      SL_DIR_B = 3'd4,
      SL_DIR_C = 3'd5,
      SL_CTL_0 = 3'd6,
      SL_CTL_1 = 3'd7
   } slot_e;

   localparam int unsigned DIR_SLOT_BASE = 3;
   localparam int unsigned CTL_SLOT_BASE = 6;
endpackage

// File: rtl/pio_decode.sv
module pio_decode #(
   parameter int unsigned ADDR_W  = 16,
   parameter logic [15:0] BASE_HI = 16'hFEF0,
   parameter logic [15:0] BASE_LO = 16'hFEC0
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        dev_sel,
   output logic                        hit,
   output logic [pio_pkg::SLOT_W-1:0]  slot
);
   localparam int unsigned SW = pio_pkg::SLOT_W;

   logic [ADDR_W-1:0] base;

   always_comb begin
      base = dev_sel ? BASE_HI[ADDR_W-1:0] : BASE_LO[ADDR_W-1:0];
      hit  = (addr[ADDR_W-1:SW] == base[ADDR_W-1:SW]);
      slot = addr[SW-1:0];
   end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
   parameter int unsigned DW   = 8,
   parameter logic [7:0]  MASK = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_dat,
   input  logic          we_dir,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] pin,
   output logic [DW-1:0] latch,
   output logic [DW-1:0] dir,
   output logic [DW-1:0] rd_dat
);
   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (MASK[b]) begin : g_live
         logic l_q, d_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               l_q <= 1'b0;
               d_q <= 1'b0;
            end else begin
               if (we_dat) l_q <= wdata[b];
               if (we_dir) d_q <= wdata[b];
            end
         end
         assign latch[b]  = l_q;
         assign dir[b]    = d_q;
         assign rd_dat[b] = d_q ? l_q : pin[b];
      end else begin : g_tie
         assign latch[b]  = 1'b0;
         assign dir[b]    = 1'b0;
         assign rd_dat[b] = 1'b0;
      end
   end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl #(
   parameter int unsigned DW   = 8,
   parameter bit          STUB = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ctl0,
   output logic [DW-1:0] ctl1
);
   if (STUB) begin : g_stub
      assign ctl0 = '0;
      assign ctl1 = '0;
   end else begin : g_regs
      logic [DW-1:0] r0, r1;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r0 <= '0;
            r1 <= '0;
         end else begin
            if (we[0]) r0 <= wdata;
            if (we[1]) r1 <= wdata;
         end
      end
      assign ctl0 = r0;
      assign ctl1 = r1;
   end
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DW        = 8,
   parameter logic [15:0] BASE_HI   = 16'hFEF0,
   parameter logic [15:0] BASE_LO   = 16'hFEC0,
   parameter logic [7:0]  MASK_A    = 8'hFF,
   parameter logic [7:0]  MASK_B    = 8'h03,
   parameter logic [7:0]  MASK_C    = 8'hC0,
   parameter bit          CTL_STUB  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              dev_sel,
   output logic [DW-1:0]     rdata,
   input  logic [DW-1:0]     pin_a,
   input  logic [DW-1:0]     pin_b,
   input  logic [DW-1:0]     pin_c,
   output logic [DW-1:0]     out_a,
   output logic [DW-1:0]     out_b,
   output logic [DW-1:0]     out_c,
   output logic [DW-1:0]     oe_a,
   output logic [DW-1:0]     oe_b,
   output logic [DW-1:0]     oe_c
);
   import pio_pkg::*;

   localparam int unsigned NP = N_PORTS;

   if (DW != 8) begin : g_bad_dw
      $error("tri_port_pio: DW must be 8");
   end
   if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_aw
      $error("tri_port_pio: ADDR_W out of range");
   end
   if (BASE_HI[2:0] != 3'd0 || BASE_LO[2:0] != 3'd0) begin : g_bad_base
      $error("tri_port_pio: bases must be 8-byte aligned");
   end
   if (BASE_HI[ADDR_W-1:3] == BASE_LO[ADDR_W-1:3]) begin : g_same_base
      $error("tri_port_pio: the two bases must differ");
   end

   logic                 hit;
   logic [SLOT_W-1:0]    slot;
   logic                 we;
   logic [NP-1:0][DW-1:0] pin_v, latch_v, dir_v, rd_v;
   logic [DW-1:0]        ctl0, ctl1;
   logic [DW-1:0]        mux;

   pio_decode #(
      .ADDR_W (ADDR_W),
      .BASE_HI(BASE_HI),
      .BASE_LO(BASE_LO)
   ) u_dec (
      .addr   (addr),
      .dev_sel(dev_sel),
      .hit    (hit),
      .slot   (slot)
   );

   assign we    = wr_en && hit;
   assign pin_v = {pin_c, pin_b, pin_a};

   for (genvar p = 0; p < NP; p++) begin : g_port
      localparam logic [7:0] PMASK = (p == 0) ? MASK_A : (p == 1) ? MASK_B : MASK_C;
      logic we_d, we_r;
      assign we_d = we && (slot == SLOT_W'(p));
      assign we_r = we && (slot == SLOT_W'(p + DIR_SLOT_BASE));
      pio_port #(
         .DW  (DW),
         .MASK(PMASK)
      ) u_port (
         .clk   (clk),
         .rst_n (rst_n),
         .we_dat(we_d),
         .we_dir(we_r),
         .wdata (wdata),
         .pin   (pin_v[p]),
         .latch (latch_v[p]),
         .dir   (dir_v[p]),
         .rd_dat(rd_v[p])
      );
   end

   pio_ctrl #(
      .DW  (DW),
      .STUB(CTL_STUB)
   ) u_ctl (
      .clk  (clk),
      .rst_n(rst_n),
      .we   ({we && (slot == SL_CTL_1), we && (slot == SL_CTL_0)}),
      .wdata(wdata),
      .ctl0 (ctl0),
      .ctl1 (ctl1)
   );

   always_comb begin
      unique case (slot_e'(slot))
         SL_DAT_A: mux = rd_v[0];
         SL_DAT_B: mux = rd_v[1];
         SL_DAT_C: mux = rd_v[2];
         SL_DIR_A: mux = dir_v[0];
         SL_DIR_B: mux = dir_v[1];
         SL_DIR_C: mux = dir_v[2];
         SL_CTL_0: mux = ctl0;
         SL_CTL_1: mux = ctl1;
         default:  mux = '0;
      endcase
   end

   assign rdata = (rd_en && hit) ? mux : '0;

   assign out_a = latch_v[0];
   assign out_b = latch_v[1];
   assign out_c = latch_v[2];
   assign oe_a  = dir_v[0];
   assign oe_b  = dir_v[1];
   assign oe_c  = dir_v[2];
endmodule

// File: rtl/tri_port_pio_chk.sv
module tri_port_pio_chk #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DW      = 8,
   parameter logic [15:0] BASE_HI = 16'hFEF0,
   parameter logic [15:0] BASE_LO = 16'hFEC0,
   parameter logic [7:0]  MASK_A  = 8'hFF,
   parameter logic [7:0]  MASK_B  = 8'h03,
   parameter logic [7:0]  MASK_C  = 8'hC0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DW-1:0]     wdata,
   input logic              wr_en,
   input logic              rd_en,
   input logic              dev_sel,
   input logic [DW-1:0]     rdata,
   input logic [DW-1:0]     out_a,
   input logic [DW-1:0]     out_b,
   input logic [DW-1:0]     out_c,
   input logic [DW-1:0]     oe_a,
   input logic [DW-1:0]     oe_b,
   input logic [DW-1:0]     oe_c
);
   // R2 / R3: write to port A data in the high window lands next cycle
   p_write_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dev_sel && addr == BASE_HI[ADDR_W-1:0])
      |=> (out_a == ($past(wdata) & MASK_A)));

   // R3: same address with the low window selected leaves port A alone
   p_window_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dev_sel && addr == BASE_HI[ADDR_W-1:0])
      |=> $stable(out_a));

   // R5: pad outputs only change after a write strobe
   p_pads_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({out_a, out_b, out_c, oe_a, oe_b, oe_c}));

   // R6: unused bits never drive
   p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_b & ~MASK_B) == '0) && ((oe_b & ~MASK_B) == '0) &&
      ((out_c & ~MASK_C) == '0) && ((oe_c & ~MASK_C) == '0) &&
      ((out_a & ~MASK_A) == '0) && ((oe_a & ~MASK_A) == '0));

   // R8: no read strobe, no read data
   p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));
endmodule

bind tri_port_pio tri_port_pio_chk #(
   .ADDR_W (ADDR_W),
   .DW     (DW),
   .BASE_HI(BASE_HI),
   .BASE_LO(BASE_LO),
   .MASK_A (MASK_A),
   .MASK_B (MASK_B),
   .MASK_C (MASK_C)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (addr),
   .wdata  (wdata),
   .wr_en  (wr_en),
   .rd_en  (rd_en),
   .dev_sel(dev_sel),
   .rdata  (rdata),
   .out_a  (out_a),
   .out_b  (out_b),
   .out_c  (out_c),
   .oe_a   (oe_a),
   .oe_b   (oe_b),
   .oe_c   (oe_c)
);

// File: tb/tri_port_pio_test.sv
module tri_port_pio_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [7:0]  wdata = 8'h00;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic        dev_sel = 1'b1;
   logic [7:0]  rdata;
   logic [7:0]  pin_a = 8'h00, pin_b = 8'h00, pin_c = 8'h00;
   logic [7:0]  out_a, out_b, out_c, oe_a, oe_b, oe_c;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [15:0] HI = 16'hFEF0;
   localparam logic [15:0] LO = 16'hFEC0;
   localparam logic [7:0] MA = 8'hFF, MB = 8'h03, MC = 8'hC0;

   always #10 clk = ~clk;

   tri_port_pio uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .dev_sel(dev_sel), .rdata(rdata),
      .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
      .out_a(out_a), .out_b(out_b), .out_c(out_c),
      .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #2 d = rdata;
      rd_en = 1'b0;
   endtask

   function automatic logic [7:0] mask_of(input int p);
      return (p == 0) ? MA : (p == 1) ? MB : MC;
   endfunction

   initial begin
      #4_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R7 control reset
      for (int s = 0; s < 8; s++) begin
         rd(HI + 16'(s), v);
         chk("R1 reset read", v, 8'h00);
      end
      chk("R1 oe_a", oe_a, 0); chk("R1 oe_b", oe_b, 0); chk("R1 oe_c", oe_c, 0);
      chk("R1 out_a", out_a, 0); chk("R1 out_b", out_b, 0); chk("R1 out_c", out_c, 0);
      rd(HI + 16'd6, v); chk("R7 reset ctl0", v, 8'h00);

      // R2 R6 direction sweep and readback, R5 oe tracks
      for (int p = 0; p < 3; p++) begin
         for (int d = 0; d < 256; d++) begin
            wr(HI + 16'(3 + p), 8'(d));
            rd(HI + 16'(3 + p), v);
            chk("R2 R6 dir readback", v, 8'(d) & mask_of(p));
            chk("R5 oe", (p == 0) ? oe_a : (p == 1) ? oe_b : oe_c, 8'(d) & mask_of(p));
         end
      end

      // R4 R6 data sweep with all outputs, pins complementary
      for (int p = 0; p < 3; p++) begin
         wr(HI + 16'(3 + p), 8'hFF);
         for (int d = 0; d < 256; d++) begin
            pin_a = ~8'(d); pin_b = ~8'(d); pin_c = ~8'(d);
            wr(HI + 16'(p), 8'(d));
            rd(HI + 16'(p), v);
            chk("R4 R6 data readback", v, 8'(d) & mask_of(p));
            chk("R5 out", (p == 0) ? out_a : (p == 1) ? out_b : out_c, 8'(d) & mask_of(p));
         end
      end

      // R4 mixed direction: latch 0x5A, pins 0xA5
      for (int p = 0; p < 3; p++) begin
         wr(HI + 16'(p), 8'h5A);
         pin_a = 8'hA5; pin_b = 8'hA5; pin_c = 8'hA5;
         for (int d = 0; d < 256; d += 7) begin
            wr(HI + 16'(3 + p), 8'(d));
            rd(HI + 16'(p), v);
            chk("R4 mixed dir read", v,
                (((8'h5A & 8'(d)) | (8'hA5 & ~8'(d))) & mask_of(p)));
         end
      end

      // R6 unused pins on B and C read 0 as inputs
      wr(HI + 16'd4, 8'h00); wr(HI + 16'd5, 8'h00);
      pin_b = 8'hFF; pin_c = 8'hFF;
      rd(HI + 16'd1, v); chk("R6 pin_b unused", v, MB);
      rd(HI + 16'd2, v); chk("R6 pin_c unused", v, MC);
      pin_a = 8'h00; pin_b = 8'h00; pin_c = 8'h00;

      // R7 control slots
      for (int s = 6; s < 8; s++)
         for (int d = 0; d < 256; d += 13) begin
            wr(HI + 16'(s), 8'(d));
            rd(HI + 16'(s), v);
            chk("R7 ctl readback", v, 8'(d));
         end

      // R3 window select
      wr(HI + 16'd3, 8'h00);
      dev_sel = 1'b1;
      wr(HI + 16'd3, 8'h3C);
      chk("R3 hi window write", oe_a, 8'h3C);
      wr(LO + 16'd3, 8'hC3);
      chk("R3 lo addr ignored when sel=1", oe_a, 8'h3C);
      rd(LO + 16'd3, v); chk("R3 lo addr reads 0 when sel=1", v, 8'h00);
      dev_sel = 1'b0;
      wr(HI + 16'd3, 8'h11);
      chk("R3 hi addr ignored when sel=0", oe_a, 8'h3C);
      rd(HI + 16'd3, v); chk("R3 hi addr reads 0 when sel=0", v, 8'h00);
      wr(LO + 16'd3, 8'h96);
      chk("R3 lo window write", oe_a, 8'h96);
      rd(LO + 16'd3, v); chk("R3 lo window read", v, 8'h96);
      wr(LO + 16'd8, 8'h01);
      wr(LO - 16'd5, 8'h02);
      chk("R3 outside window", oe_a, 8'h96);
      rd(LO + 16'd8, v); chk("R3 outside read", v, 8'h00);
      dev_sel = 1'b1;

      // R8 no read strobe
      @(negedge clk);
      addr = HI + 16'd3; rd_en = 1'b0;
      #2 chk("R8 rd_en low", rdata, 8'h00);

      // R9 start-up sequence
      wr(HI + 16'd3, 8'hFF);
      wr(HI + 16'd4, 8'h00);
      wr(HI + 16'd5, 8'h40);
      wr(HI + 16'd0, 8'h00);
      wr(HI + 16'd2, 8'h40);
      pin_c = 8'h80;
      @(negedge clk);
      chk("R9 oe_a", oe_a, 8'hFF);
      chk("R9 out_a", out_a, 8'h00);
      chk("R9 oe_c", oe_c, 8'h40);
      chk("R9 out_c", out_c, 8'h40);
      rd(HI + 16'd2, v); chk("R9 port C read", v, 8'hC0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule